// File: doc/BRIEF.md
# E2 Multiplex Frame Generator

This block assembles the outgoing 848-bit second-order frame that carries four asynchronous 2048 kbit/s tributaries in one 8448 kbit/s NRZ stream. Each clock cycle in which the bit-rate enable is high, the block emits one frame bit. It also pulses a per-tributary read strobe whenever that bit is taken from a tributary's elastic buffer. The buffers are outside the block. Each one presents its next bit and a fill level. The generator pulls bits from the buffers and decides, once per frame, which tributaries skip their justification opportunity.

The frame has four sets of 212 bits:
- Set I holds the ten-bit alignment word, a remote alarm bit, a spare bit and 200 data bits.
- Sets II and III each start with a four-bit justification control group, followed by 208 data bits.
- Set IV holds a control group, four justification opportunity bits and 204 data bits.

In every data field the tributaries are bit-interleaved. Software-driven inputs set the alarm bit and the spare bit. A third input deliberately spoils the alignment word of every frame while it is held high.

Top module: `e2_frame_gen`

## Requirements
- R1: While `rst` is high, `line_bit` and `frame_sync` are 0 and `trib_rd` is all zeros, whatever `bit_en` does.
- R2: Frame bits are emitted only on cycles with `bit_en` high. `frame_sync` is 1 exactly while the emitted bit is bit 1, and the distance from one bit 1 to the next is 848 enables.
- R3: With `corrupt_fas` low, bits 1 to 10 are 1,1,1,1,0,1,0,0,0,0 in transmission order.
- R4: Bit 11 equals `alarm_bit` and bit 12 equals `spare_bit`, each sampled on the enable cycle that emits that bit.
- R5: With `corrupt_fas` high on the enable cycle of bit 1, that bit goes out as 0 and bits 2 to 10 are unchanged. This repeats in every frame for as long as the input stays high.
- R6: Data bits occupy positions 13..212, 217..424, 429..636 and 645..848. In each field, tributaries 1, 2, 3, 4 (`trib_bit[0..3]`) take turns starting with tributary 1. Each data bit equals that tributary's `trib_bit` on the emitting cycle, and `trib_rd` is one-hot on that tributary in the same cycle.
- R7: Positions 213..216, 425..428 and 637..640 are three justification control groups. The k-th bit of each group is 1 if tributary k is justified in this frame and 0 otherwise.
- R8: Positions 641..644 are the opportunity bits of tributaries 1..4. A justified tributary's opportunity bit is a dummy 1 with no read strobe. Otherwise the bit carries data as in R6, with a read strobe.
- R9: Tributary k is justified for a whole frame if its 4-bit fill field `trib_fill[4k-1 -: 4]` (k = 1..4) is below `STUFF_THRESH` (default 4) on the enable cycle of that frame's bit 1.
- R10: On cycles with `bit_en` low, `trib_rd` is zero, and `line_bit` and `frame_sync` keep their values.
- R11: Per frame, each tributary is read 206 times if not justified and 205 times if justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle enable at the 8448 kHz bit rate |
| trib_bit | input | 4 | Next bit offered by each tributary buffer (bit 0 = tributary 1) |
| trib_fill | input | 16 | Fill level of each tributary buffer, 4 bits each |
| alarm_bit | input | 1 | Value sent in the remote alarm position |
| spare_bit | input | 1 | Value sent in the spare position |
| corrupt_fas | input | 1 | Spoil the alignment word of each frame while high |
| trib_rd | output | 4 | Read strobe, one-hot, to the tributary whose bit is taken |
| line_bit | output | 1 | Serial NRZ frame bit, registered |
| frame_sync | output | 1 | High while `line_bit` holds frame bit 1 |

## Verification
Justification is hard to reach from the ports. It is latched once per frame, and its effect is spread over three distant control groups, the opportunity bits and the per-tributary read totals. The stimulus holds the fill levels steady across whole frames, with fills just below and exactly at the threshold on different tributaries. It then compares every bit of a full captured frame and counts the read strobes of each tributary. Further frames cover alignment corruption on consecutive frames and its removal. A gapped enable, high one cycle in three, checks that nothing moves between enables.

// File: rtl/e2fg_pkg.sv
package e2fg_pkg;

    localparam int NTRIB       = 4;
    localparam int SET_LEN     = 212;
    localparam int NSETS       = 4;
    localparam int FRAME_LEN   = SET_LEN * NSETS;
    localparam int POS_W       = $clog2(FRAME_LEN);
    localparam int OFF_W       = $clog2(SET_LEN);
    localparam int SET_W       = $clog2(NSETS);
    localparam int TRIB_W      = $clog2(NTRIB);
    localparam int FAS_LEN     = 10;
    localparam int FAS_IDX_W   = $clog2(FAS_LEN);
    localparam logic [FAS_LEN-1:0] FAS_WORD = 10'b1111010000;
    localparam int FAS_FLIP    = 0;
    localparam int SET1_OVH    = FAS_LEN + 2;
    localparam int CTRL_LEN    = NTRIB;
    localparam int JOPP_LEN    = NTRIB;
    localparam logic DUMMY_BIT = 1'b1;

    typedef enum logic [2:0] {
        SL_FAS, SL_ALARM, SL_SPARE, SL_CTRL, SL_JOPP, SL_DATA
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e             kind;
        logic [TRIB_W-1:0]      trib;
        logic [FAS_IDX_W-1:0]   fas_idx;
    } slot_t;

    // Map (set, offset) to the content class of that frame position.
    function automatic slot_t classify(input logic [SET_W-1:0] set_i,
                                       input logic [OFF_W-1:0] off_i);
        slot_t s;
        int    o;
        int    base;
        o         = int'(off_i);
        base      = 0;
        s.kind    = SL_DATA;
        s.trib    = '0;
        s.fas_idx = '0;
        if (set_i == '0) begin
            if (o < FAS_LEN) begin
                s.kind    = SL_FAS;
                s.fas_idx = FAS_IDX_W'(o);
            end else if (o == FAS_LEN) begin
                s.kind = SL_ALARM;
            end else if (o == FAS_LEN + 1) begin
                s.kind = SL_SPARE;
            end else begin
                base = SET1_OVH;
            end
        end else if (o < CTRL_LEN) begin
            s.kind = SL_CTRL;
            s.trib = TRIB_W'(o);
        end else if (set_i == SET_W'(NSETS - 1) && o < CTRL_LEN + JOPP_LEN) begin
            s.kind = SL_JOPP;
            s.trib = TRIB_W'(o - CTRL_LEN);
        end else begin
            base = (set_i == SET_W'(NSETS - 1)) ? CTRL_LEN + JOPP_LEN : CTRL_LEN;
        end
        if (s.kind == SL_DATA)
            s.trib = TRIB_W'((o - base) % NTRIB);
        return s;
    endfunction

    // Alignment word bit, first transmitted bit is the MSB.
    function automatic logic fas_bit(input logic [FAS_IDX_W-1:0] idx,
                                     input logic corrupt);
        logic b;
        b = FAS_WORD[FAS_LEN - 1 - int'(idx)];
        if (corrupt && int'(idx) == FAS_FLIP)
            b = ~b;
        return b;
    endfunction

endpackage

// File: rtl/e2fg_position.sv
module e2fg_position
    import e2fg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [SET_W-1:0] set_o,
    output logic [OFF_W-1:0] off_o,
    output logic             at_start_o
);

    logic [SET_W-1:0] set_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
            off_q <= '0;
        end else if (adv) begin
            if (off_q == OFF_W'(SET_LEN - 1)) begin
                off_q <= '0;
                set_q <= (set_q == SET_W'(NSETS - 1)) ? '0 : set_q + 1'b1;
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    assign set_o      = set_q;
    assign off_o      = off_q;
    assign at_start_o = (set_q == '0) && (off_q == '0);

endmodule

// File: rtl/e2fg_justify.sv
module e2fg_justify
    import e2fg_pkg::*;
#(
    parameter int FILL_W       = 4,
    parameter int STUFF_THRESH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    latch,
    input  logic [NTRIB*FILL_W-1:0] fill,
    output logic [NTRIB-1:0]        stuff_o
);

    logic [NTRIB-1:0] stuff_q;

    for (genvar g = 0; g < NTRIB; g++) begin : g_trib
        always_ff @(posedge clk) begin
            if (rst)
                stuff_q[g] <= 1'b0;
            else if (latch)
                stuff_q[g] <= fill[g*FILL_W +: FILL_W] < FILL_W'(STUFF_THRESH);
        end
    end

    assign stuff_o = stuff_q;

endmodule

// File: rtl/e2fg_bitsel.sv
module e2fg_bitsel
    import e2fg_pkg::*;
(
    input  slot_t            slot,
    input  logic             en,
    input  logic             alarm,
    input  logic             spare,
    input  logic             corrupt,
    input  logic [NTRIB-1:0] stuff,
    input  logic [NTRIB-1:0] trib_bit,
    output logic             bit_o,
    output logic [NTRIB-1:0] rd_o
);

    logic take;

    always_comb begin
        take  = 1'b0;
        bit_o = 1'b0;
        unique case (slot.kind)
            SL_FAS:   bit_o = fas_bit(slot.fas_idx, corrupt);
            SL_ALARM: bit_o = alarm;
            SL_SPARE: bit_o = spare;
            SL_CTRL:  bit_o = stuff[slot.trib];
            SL_JOPP: begin
                take  = ~stuff[slot.trib];
                bit_o = stuff[slot.trib] ? DUMMY_BIT : trib_bit[slot.trib];
            end
            SL_DATA: begin
                take  = 1'b1;
                bit_o = trib_bit[slot.trib];
            end
            default: bit_o = 1'b0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NTRIB; i++)
            rd_o[i] = en && take && (slot.trib == TRIB_W'(i));
    end

endmodule

// File: rtl/e2_frame_gen.sv
module e2_frame_gen
    import e2fg_pkg::*;
#(
    parameter int FILL_W       = 4,
    parameter int STUFF_THRESH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic [NTRIB-1:0]        trib_bit,
    input  logic [NTRIB*FILL_W-1:0] trib_fill,
    input  logic                    alarm_bit,
    input  logic                    spare_bit,
    input  logic                    corrupt_fas,
    output logic [NTRIB-1:0]        trib_rd,
    output logic                    line_bit,
    output logic                    frame_sync
);

    logic             adv;
    logic [SET_W-1:0] set_w;
    logic [OFF_W-1:0] off_w;
    logic             at_start;
    logic [NTRIB-1:0] stuff;
    slot_t            slot;
    logic             next_bit;
    logic             line_q;
    logic             sync_q;

    assign adv  = bit_en && !rst;
    assign slot = classify(set_w, off_w);

    e2fg_position u_pos (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .set_o      (set_w),
        .off_o      (off_w),
        .at_start_o (at_start)
    );

    e2fg_justify #(
        .FILL_W       (FILL_W),
        .STUFF_THRESH (STUFF_THRESH)
    ) u_just (
        .clk     (clk),
        .rst     (rst),
        .latch   (adv && at_start),
        .fill    (trib_fill),
        .stuff_o (stuff)
    );

    // Control groups follow bit 1, so the freshly latched decision is used.
    e2fg_bitsel u_sel (
        .slot     (slot),
        .en       (adv),
        .alarm    (alarm_bit),
        .spare    (spare_bit),
        .corrupt  (corrupt_fas),
        .stuff    (stuff),
        .trib_bit (trib_bit),
        .bit_o    (next_bit),
        .rd_o     (trib_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            sync_q <= 1'b0;
        end else if (bit_en) begin
            line_q <= next_bit;
            sync_q <= at_start;
        end
    end

    assign line_bit   = line_q;
    assign frame_sync = sync_q;

endmodule

// File: rtl/e2fg_checker.sv
module e2fg_checker
    import e2fg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             alarm_bit,
    input logic             spare_bit,
    input logic             corrupt_fas,
    input logic             line_bit,
    input logic             frame_sync,
    input logic [NTRIB-1:0] trib_rd
);

    logic [POS_W-1:0] ck_pos;

    always_ff @(posedge clk) begin
        if (rst)
            ck_pos <= '0;
        else if (bit_en)
            ck_pos <= (ck_pos == POS_W'(FRAME_LEN - 1)) ? '0 : ck_pos + 1'b1;
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_bit) && $stable(frame_sync));

    // R10
    no_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |-> trib_rd == '0);

    // R6
    read_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trib_rd));

    // R2
    sync_period_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> frame_sync == ($past(ck_pos) == '0));

    // R5
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en && ck_pos == '0 |=> line_bit == !$past(corrupt_fas));

    // R4
    alarm_pos_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en && ck_pos == POS_W'(FAS_LEN) |=> line_bit == $past(alarm_bit));

    // R4
    spare_pos_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en && ck_pos == POS_W'(FAS_LEN + 1) |=> line_bit == $past(spare_bit));

endmodule

bind e2_frame_gen e2fg_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .alarm_bit   (alarm_bit),
    .spare_bit   (spare_bit),
    .corrupt_fas (corrupt_fas),
    .line_bit    (line_bit),
    .frame_sync  (frame_sync),
    .trib_rd     (trib_rd)
);

// File: tb/e2_frame_gen_test.sv
module e2_frame_gen_test;

    localparam int FLEN = 848;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b1;
    logic [3:0]  trib_bit = '0;
    logic [15:0] trib_fill = '0;
    logic        alarm_bit = 1'b0;
    logic        spare_bit = 1'b0;
    logic        corrupt_fas = 1'b0;
    logic [3:0]  trib_rd;
    logic        line_bit;
    logic        frame_sync;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    bit  gap_mode = 0;
    int  cyc = 0;

    e2_frame_gen uut (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .trib_bit    (trib_bit),
        .trib_fill   (trib_fill),
        .alarm_bit   (alarm_bit),
        .spare_bit   (spare_bit),
        .corrupt_fas (corrupt_fas),
        .trib_rd     (trib_rd),
        .line_bit    (line_bit),
        .frame_sync  (frame_sync)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            bit_en = gap_mode ? (cyc % 3 == 0) : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Kinds: 0 align, 1 alarm, 2 spare, 3 control, 4 opportunity, 5 data
    function automatic int kind_of(input int q, output int t);
        t = 0;
        if (q < 10) return 0;
        if (q == 10) return 1;
        if (q == 11) return 2;
        if (q < 212) begin t = (q - 12) % 4; return 5; end
        if (q < 216) begin t = q - 212; return 3; end
        if (q < 424) begin t = (q - 216) % 4; return 5; end
        if (q < 428) begin t = q - 424; return 3; end
        if (q < 636) begin t = (q - 428) % 4; return 5; end
        if (q < 640) begin t = q - 636; return 3; end
        if (q < 644) begin t = q - 640; return 4; end
        t = (q - 644) % 4;
        return 5;
    endfunction

    task automatic check_frame(input logic [3:0] pat, input logic [3:0] stf,
                               input logic al, input logic sp, input logic cor,
                               input string tag);
        int fas_seen = 0;
        int fas_exp;
        int sync_err = 0, ctrl_err = 0, jopp_err = 0, data_err = 0, rd_err = 0;
        int al_seen = 0, sp_seen = 0;
        int rd_cnt[4];
        int guard = 0;
        for (int i = 0; i < 4; i++) rd_cnt[i] = 0;
        fas_exp = cor ? 10'b0111010000 : 10'b1111010000;
        @(negedge clk);
        while (!frame_sync && guard < 2 * FLEN) begin
            @(negedge clk);
            guard++;
        end
        for (int j = 0; j < FLEN; j++) begin
            int t, k, tn, kn, q;
            logic [3:0] rd_exp;
            if (j > 0) @(negedge clk);
            if (frame_sync != (j == 0)) sync_err++;
            k = kind_of(j, t);
            case (k)
                0: fas_seen = (fas_seen << 1) | int'(line_bit);
                1: al_seen = int'(line_bit);
                2: sp_seen = int'(line_bit);
                3: if (line_bit != stf[t]) ctrl_err++;
                4: if (line_bit != (stf[t] ? 1'b1 : pat[t])) jopp_err++;
                default: if (line_bit != pat[t]) data_err++;
            endcase
            q  = (j + 1) % FLEN;
            kn = kind_of(q, tn);
            rd_exp = ((kn == 5) || (kn == 4 && !stf[tn])) ? 4'(1 << tn) : 4'b0;
            if (trib_rd != rd_exp) rd_err++;
            for (int i = 0; i < 4; i++) if (trib_rd[i]) rd_cnt[i]++;
        end
        chk(sync_err == 0, {tag, " R2 frame_sync once per 848 bits"}, sync_err, 0);
        chk(fas_seen == fas_exp, {tag, cor ? " R5 spoiled word" : " R3 alignment word"},
            fas_seen, fas_exp);
        chk(al_seen == int'(al), {tag, " R4 alarm bit"}, al_seen, int'(al));
        chk(sp_seen == int'(sp), {tag, " R4 spare bit"}, sp_seen, int'(sp));
        chk(ctrl_err == 0, {tag, " R7 control groups"}, ctrl_err, 0);
        chk(jopp_err == 0, {tag, " R8 opportunity bits"}, jopp_err, 0);
        chk(data_err == 0, {tag, " R6 interleaved data"}, data_err, 0);
        chk(rd_err == 0, {tag, " R6 read strobe position"}, rd_err, 0);
        for (int i = 0; i < 4; i++)
            chk(rd_cnt[i] == (stf[i] ? 205 : 206), {tag, " R11 reads per tributary"},
                rd_cnt[i], stf[i] ? 205 : 206);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(line_bit == 1'b0, "R1 line_bit in reset", int'(line_bit), 0);
        chk(frame_sync == 1'b0, "R1 frame_sync in reset", int'(frame_sync), 0);
        chk(trib_rd == 4'b0, "R1 trib_rd in reset", int'(trib_rd), 0);
        rst = 1'b0;
    endtask

    task automatic t_plain;
        trib_bit = 4'b0101; trib_fill = 16'h8888;
        alarm_bit = 1'b1; spare_bit = 1'b0; corrupt_fas = 1'b0;
        check_frame(4'b0101, 4'b0000, 1'b1, 1'b0, 1'b0, "plain");
    endtask

    task automatic t_stuff_boundary;
        // R9: tributary fills 3,4,0,15 against threshold 4
        trib_bit = 4'b0011; trib_fill = {4'd15, 4'd0, 4'd4, 4'd3};
        alarm_bit = 1'b0; spare_bit = 1'b1;
        check_frame(4'b0011, 4'b0101, 1'b0, 1'b1, 1'b0, "R9 boundary");
    endtask

    task automatic t_corrupt;
        trib_bit = 4'b1110; trib_fill = 16'h2222;
        alarm_bit = 1'b1; spare_bit = 1'b1; corrupt_fas = 1'b1;
        check_frame(4'b1110, 4'b1111, 1'b1, 1'b1, 1'b1, "R5 first");
        check_frame(4'b1110, 4'b1111, 1'b1, 1'b1, 1'b1, "R5 second");
        corrupt_fas = 1'b0;
        check_frame(4'b1110, 4'b1111, 1'b1, 1'b1, 1'b0, "R5 released");
    endtask

    task automatic t_gapped;
        logic prev_en, prev_line, prev_sync;
        int stab_err = 0, idle_rd = 0, ens = 0, last = -1, periods = 0, per_err = 0;
        gap_mode = 1;
        @(negedge clk);
        prev_en = bit_en; prev_line = line_bit; prev_sync = frame_sync;
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            if (!prev_en && (line_bit != prev_line || frame_sync != prev_sync)) stab_err++;
            if (!bit_en && trib_rd != 4'b0) idle_rd++;
            if (prev_en) begin
                ens++;
                if (frame_sync) begin
                    if (last >= 0) begin
                        periods++;
                        if (ens - last != FLEN) per_err++;
                    end
                    last = ens;
                end
            end
            prev_en = bit_en; prev_line = line_bit; prev_sync = frame_sync;
        end
        gap_mode = 0;
        chk(stab_err == 0, "R10 outputs hold between enables", stab_err, 0);
        chk(idle_rd == 0, "R10 no read without enable", idle_rd, 0);
        chk(periods >= 1 && per_err == 0, "R2 frame length under gapped enable",
            per_err, 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_stuff_boundary();
        t_corrupt();
        t_gapped();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule